// File: doc/BRIEF.md
# Four-Level Virtual Address Translation Walker

This block turns a 64-bit virtual address into a physical address by reading a four-level tree of translation tables that lives in memory. A client hands over the virtual address and the physical base of the top-level table. The walker first confirms that the address is sign-extended correctly. An address that fails this check is rejected at once and no memory is read. A legal address is then resolved with one 64-bit entry read per level over a simple request/response port. The walker returns either a physical address with a page-size code, or a fault code and the level that failed.

Each level selects one of 512 entries with a 9-bit slice of the address. The walk can end early at the third level with a 1 GB page or at the second level with a 2 MB page. Otherwise it runs to the last level and yields a 4 KB page. The walker serves one request at a time and drops its ready output until the result has been presented.

Entry layout: bit 0 marks the entry as present, bit 7 marks a large page, and bits 51:12 carry the next table base or the frame base. The other entry bits take no part in translation.

Top module: `pgwalk_top`

## Requirements
- R1: While and directly after reset, req_ready is 1 and both res_valid and mem_req_valid are 0.
- R2: An address whose bits 63:48 are not all equal to bit 47 finishes with res_fault = 1 (non-canonical), res_level = 0, res_size = 0 and res_pa = 0, and issues no memory read.
- R3: The first entry is read at {req_root[51:12], 12'h0} + 8 × VA[47:39]; bits 11:0 of req_root are ignored. Later levels use entry bits 51:12 as the table base and index fields VA[38:30], VA[29:21] and VA[20:12].
- R4: A walk ending at level 1 makes four reads and returns res_fault = 0, res_size = 0 (4 KB), res_level = 1 and res_pa = {entry[51:12], VA[11:0]}. Entry bits 63:52 are ignored.
- R5: A present level-2 entry with bit 7 set ends the walk after three reads with res_size = 1 (2 MB), res_level = 2 and res_pa = {entry[51:21], VA[20:0]}.
- R6: A present level-3 entry with bit 7 set ends the walk after two reads with res_size = 2 (1 GB), res_level = 3 and res_pa = {entry[51:30], VA[29:0]}. Entry bits 29:12 are ignored.
- R7: Bit 7 has no effect in level-4 and level-1 entries: the walk continues past level 4, and level 1 still yields a 4 KB page.
- R8: An entry with bit 0 clear at level n (4 down to 1) ends the walk after 5−n reads with res_fault = 2, res_level = n, res_size = 0 and res_pa = 0.
- R9: A request is taken only when req_ready and req_valid are both 1. req_ready stays 0 from that cycle until the cycle after the one-cycle res_valid pulse, so a request held during a walk is taken only after the current result.
- R10: The boundary addresses 0x00007FFF_FFFFFFFF and 0xFFFF8000_00000000 pass the canonical check and proceed to table reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 64 | Virtual address to translate |
| req_root | input | 52 | Physical base of the top-level table |
| mem_req_valid | output | 1 | One-cycle pulse issuing an entry read |
| mem_req_addr | output | 52 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Entry read data is valid |
| mem_rsp_data | input | 64 | Entry read data |
| res_valid | output | 1 | One-cycle result pulse |
| res_fault | output | 2 | 0 none, 1 non-canonical, 2 not present |
| res_level | output | 3 | Level of the terminating entry (0 for non-canonical) |
| res_size | output | 2 | 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| res_pa | output | 52 | Translated physical address |

## Verification
Two things can happen in the same cycle: the end of one walk, when the result pulse goes out, and a new request waiting at the input. The bench provokes this by raising req_valid with a second address straight after the first request is taken, and holding it through the whole walk. It then checks three things. The first result belongs to the first address. req_ready is still low while that result is presented. The second address is taken only afterwards and is translated correctly.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    localparam int PGW_VA_W   = 64;
    localparam int PGW_IMPL_W = 48;
    localparam int PGW_PA_W   = 52;
    localparam int PGW_IDX_W  = 9;
    localparam int PGW_OFF_W  = 12;
    localparam int PGW_PTE_W  = 64;
    localparam int PGW_LEVELS = 4;

    localparam int PTE_PRESENT_BIT = 0;
    localparam int PTE_LARGE_BIT   = 7;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CANON, ST_RD_L4, ST_RD_L3, ST_RD_L2, ST_RD_L1, ST_DONE
    } walk_st_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0, FLT_NONCANON = 2'd1, FLT_ABSENT = 2'd2
    } flt_e;

    typedef enum logic [1:0] {
        PG_4K = 2'd0, PG_2M = 2'd1, PG_1G = 2'd2
    } pgsz_e;

    // zero-based level of a read state (3 = top table)
    function automatic logic [1:0] lvl_of(walk_st_e s);
        case (s)
            ST_RD_L4: lvl_of = 2'd3;
            ST_RD_L3: lvl_of = 2'd2;
            ST_RD_L2: lvl_of = 2'd1;
            default:  lvl_of = 2'd0;
        endcase
    endfunction

    function automatic walk_st_e next_rd(walk_st_e s);
        case (s)
            ST_RD_L4: next_rd = ST_RD_L3;
            ST_RD_L3: next_rd = ST_RD_L2;
            default:  next_rd = ST_RD_L1;
        endcase
    endfunction

    function automatic pgsz_e size_of(logic [1:0] lvl);
        case (lvl)
            2'd2:    size_of = PG_1G;
            2'd1:    size_of = PG_2M;
            default: size_of = PG_4K;
        endcase
    endfunction
endpackage

// File: rtl/pgw_canon.sv
module pgw_canon #(
    parameter int VA_W   = 64,
    parameter int IMPL_W = 48
) (
    input  logic [VA_W-1:0] va,
    output logic            ok
);
    localparam int EXT_W = VA_W - IMPL_W + 1;
    logic [EXT_W-1:0] ext;
    assign ext = va[VA_W-1:IMPL_W-1];
    assign ok  = (&ext) | ~(|ext);
endmodule

// File: rtl/pgw_index.sv
module pgw_index #(
    parameter int VA_W   = 64,
    parameter int PA_W   = 52,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    parameter int LEVELS = 4,
    parameter int PTE_W  = 64
) (
    input  logic [VA_W-1:0]           va,
    input  logic [PA_W-1:0]           base,
    input  logic [$clog2(LEVELS)-1:0] lvl,
    output logic [PA_W-1:0]           entry_addr
);
    localparam int ENT_SH = $clog2(PTE_W / 8);
    logic [IDX_W-1:0] idx [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign idx[g] = va[OFF_W + g*IDX_W +: IDX_W];
    end

    assign entry_addr = base + (PA_W'(idx[lvl]) << ENT_SH);
endmodule

// File: rtl/pgw_frame.sv
module pgw_frame #(
    parameter int VA_W   = 64,
    parameter int PA_W   = 52,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    parameter int LEVELS = 4
) (
    input  logic [PA_W-1:0]           pte,
    input  logic [VA_W-1:0]           va,
    input  logic [$clog2(LEVELS)-1:0] lvl,
    output logic [PA_W-1:0]           pa
);
    logic [PA_W-1:0] cand [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_sz
        localparam int SH = OFF_W + g*IDX_W;
        logic [PA_W-1:0] low_mask;
        assign low_mask = (PA_W'(1) << SH) - PA_W'(1);
        assign cand[g]  = (pte & ~low_mask) | (va[PA_W-1:0] & low_mask);
    end

    assign pa = cand[lvl];
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgw_pkg::*;
#(
    parameter int VA_W   = PGW_VA_W,
    parameter int IMPL_W = PGW_IMPL_W,
    parameter int PA_W   = PGW_PA_W,
    parameter int IDX_W  = PGW_IDX_W,
    parameter int OFF_W  = PGW_OFF_W,
    parameter int PTE_W  = PGW_PTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic [PA_W-1:0]   req_root,
    output logic              mem_req_valid,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic              res_valid,
    output logic [1:0]        res_fault,
    output logic [2:0]        res_level,
    output logic [1:0]        res_size,
    output logic [PA_W-1:0]   res_pa
);
    localparam int LEVELS = PGW_LEVELS;
    localparam int LVL_W  = $clog2(LEVELS);

    walk_st_e        state_q;
    logic [VA_W-1:0] va_q;
    logic [PA_W-1:0] base_q;
    logic            sent_q;
    flt_e            fault_q;
    logic [2:0]      level_q;
    pgsz_e           size_q;
    logic [PA_W-1:0] pa_q;

    logic             canon_ok;
    logic [LVL_W-1:0] cur_lvl;
    logic             in_read;
    logic [PA_W-1:0]  frame_pa;
    logic [PA_W-1:0]  pte_base;
    logic             pte_present;
    logic             pte_large;
    logic             may_be_large;

    pgw_canon #(.VA_W(VA_W), .IMPL_W(IMPL_W)) u_canon (
        .va(va_q), .ok(canon_ok)
    );

    pgw_index #(.VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
                .LEVELS(LEVELS), .PTE_W(PTE_W)) u_index (
        .va(va_q), .base(base_q), .lvl(cur_lvl), .entry_addr(mem_req_addr)
    );

    pgw_frame #(.VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
                .LEVELS(LEVELS)) u_frame (
        .pte(mem_rsp_data[PA_W-1:0]), .va(va_q), .lvl(cur_lvl), .pa(frame_pa)
    );

    assign cur_lvl      = lvl_of(state_q);
    assign in_read      = (state_q == ST_RD_L4) || (state_q == ST_RD_L3) ||
                          (state_q == ST_RD_L2) || (state_q == ST_RD_L1);
    assign pte_present  = mem_rsp_data[PTE_PRESENT_BIT];
    assign pte_large    = mem_rsp_data[PTE_LARGE_BIT];
    assign may_be_large = (state_q == ST_RD_L3) || (state_q == ST_RD_L2);
    assign pte_base     = {mem_rsp_data[PA_W-1:OFF_W], {OFF_W{1'b0}}};

    assign req_ready     = (state_q == ST_IDLE);
    assign mem_req_valid = in_read && !sent_q;
    assign res_valid     = (state_q == ST_DONE);
    assign res_fault     = fault_q;
    assign res_level     = level_q;
    assign res_size      = size_q;
    assign res_pa        = pa_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            va_q    <= '0;
            base_q  <= '0;
            sent_q  <= 1'b0;
            fault_q <= FLT_NONE;
            level_q <= '0;
            size_q  <= PG_4K;
            pa_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_va;
                        base_q  <= {req_root[PA_W-1:OFF_W], {OFF_W{1'b0}}};
                        fault_q <= FLT_NONE;
                        level_q <= '0;
                        size_q  <= PG_4K;
                        pa_q    <= '0;
                        state_q <= ST_CANON;
                    end
                end
                ST_CANON: begin
                    sent_q <= 1'b0;
                    if (canon_ok) begin
                        state_q <= ST_RD_L4;
                    end else begin
                        fault_q <= FLT_NONCANON;
                        state_q <= ST_DONE;
                    end
                end
                ST_RD_L4, ST_RD_L3, ST_RD_L2, ST_RD_L1: begin
                    if (mem_req_valid) sent_q <= 1'b1;
                    if (mem_rsp_valid) begin
                        sent_q <= 1'b0;
                        if (!pte_present) begin
                            fault_q <= FLT_ABSENT;
                            level_q <= 3'({1'b0, cur_lvl}) + 3'd1;
                            state_q <= ST_DONE;
                        end else if ((pte_large && may_be_large) || state_q == ST_RD_L1) begin
                            level_q <= 3'({1'b0, cur_lvl}) + 3'd1;
                            size_q  <= size_of(cur_lvl);
                            pa_q    <= frame_pa;
                            state_q <= ST_DONE;
                        end else begin
                            base_q  <= pte_base;
                            state_q <= next_rd(state_q);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
    parameter int VA_W   = 64,
    parameter int IMPL_W = 48,
    parameter int PA_W   = 52,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    parameter int PTE_W  = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_va,
    input logic [PA_W-1:0] req_root,
    input logic            mem_req_valid,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            res_valid,
    input logic [1:0]      res_fault,
    input logic [2:0]      res_level,
    input logic [1:0]      res_size,
    input logic [PA_W-1:0] res_pa
);
    localparam int ENT_SH = $clog2(PTE_W / 8);
    localparam int EXT_W  = VA_W - IMPL_W + 1;
    localparam int SH_1G  = OFF_W + 2*IDX_W;

    logic [VA_W-1:0] va_c;
    logic [PA_W-1:0] root_c;
    logic [2:0]      rd_cnt;
    logic            first_pend;
    logic            va_legal;
    logic [PA_W-1:0] first_addr;

    assign va_legal   = ($countones(va_c[VA_W-1:IMPL_W-1]) == 0) ||
                        ($countones(va_c[VA_W-1:IMPL_W-1]) == EXT_W);
    assign first_addr = {root_c[PA_W-1:OFF_W], {OFF_W{1'b0}}} +
                        (PA_W'(va_c[IMPL_W-1 -: IDX_W]) << ENT_SH);

    always_ff @(posedge clk) begin
        if (rst) begin
            va_c <= '0; root_c <= '0; rd_cnt <= '0; first_pend <= 1'b0;
        end else if (req_valid && req_ready) begin
            va_c <= req_va; root_c <= req_root; rd_cnt <= '0; first_pend <= 1'b1;
        end else if (mem_req_valid) begin
            rd_cnt <= rd_cnt + 3'd1; first_pend <= 1'b0;
        end
    end

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) rst |=> (req_ready && !res_valid && !mem_req_valid)); // R1
    AST_NONCANON_SILENT: assert property (@(posedge clk) disable iff (rst) (res_valid && res_fault == 2'd1) |-> (rd_cnt == 3'd0 && !va_legal)); // R2
    AST_LEGAL_WALKED: assert property (@(posedge clk) disable iff (rst) (res_valid && va_legal) |-> (res_fault != 2'd1)); // R10
    AST_ROOT_ENTRY: assert property (@(posedge clk) disable iff (rst) (mem_req_valid && first_pend) |-> (mem_req_addr == first_addr)); // R3
    AST_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (rst) mem_req_valid |-> (mem_req_addr[ENT_SH-1:0] == '0)); // R3
    AST_PAGE_READS: assert property (@(posedge clk) disable iff (rst) (res_valid && res_fault == 2'd0) |-> (rd_cnt == 3'(3'd4 - {1'b0, res_size}))); // R4
    AST_OFFSET_4K: assert property (@(posedge clk) disable iff (rst) (res_valid && res_fault == 2'd0 && res_size == 2'd0) |-> (res_pa[OFF_W-1:0] == va_c[OFF_W-1:0])); // R4
    AST_OFFSET_1G: assert property (@(posedge clk) disable iff (rst) (res_valid && res_fault == 2'd0 && res_size == 2'd2) |-> (res_pa[SH_1G-1:0] == va_c[SH_1G-1:0])); // R6
    AST_ABSENT_READS: assert property (@(posedge clk) disable iff (rst) (res_valid && res_fault == 2'd2) |-> (rd_cnt == 3'(3'd5 - res_level) && res_pa == '0)); // R8
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst) (req_valid && req_ready) |=> !req_ready); // R9
    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (rst) res_valid |=> (!res_valid && req_ready)); // R9
endmodule

bind pgwalk_top pgwalk_chk #(
    .VA_W(VA_W), .IMPL_W(IMPL_W), .PA_W(PA_W),
    .IDX_W(IDX_W), .OFF_W(OFF_W), .PTE_W(PTE_W)
) u_chk (.*);

// File: tb/pgwalk_top_bench.sv
module pgwalk_top_bench;
    timeunit 1ns; timeprecision 1ps;

    typedef struct packed {
        logic [63:0] va;
        logic [51:0] root;
        logic [1:0]  kind;
        logic [2:0]  lvl;
        logic [1:0]  size;
        logic [51:0] pa;
        logic [2:0]  reads;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{64'h0000_0080_0000_0ABC, 52'h1000, 2'd0, 3'd1, 2'd0, 52'h1234_5ABC, 3'd4, 4'd4},  // R4
        '{64'h0000_0080_0020_3123, 52'h1000, 2'd0, 3'd2, 2'd1, 52'h00A0_3123, 3'd3, 4'd5},  // R5
        '{64'h0000_0080_40A0_7456, 52'h1000, 2'd0, 3'd3, 2'd2, 52'h40A0_7456, 3'd2, 4'd6},  // R6
        '{64'h0000_0100_0000_0000, 52'h1000, 2'd2, 3'd4, 2'd0, 52'h0,         3'd1, 4'd8},  // R8 level 4
        '{64'h0000_0080_8000_0000, 52'h1000, 2'd2, 3'd3, 2'd0, 52'h0,         3'd2, 4'd8},  // R8 level 3
        '{64'h0000_0080_0040_0000, 52'h1000, 2'd2, 3'd2, 2'd0, 52'h0,         3'd3, 4'd8},  // R8 level 2
        '{64'h0000_0080_0000_1000, 52'h1000, 2'd2, 3'd1, 2'd0, 52'h0,         3'd4, 4'd8},  // R8 level 1
        '{64'h0000_0080_C000_5FFF, 52'h1000, 2'd0, 3'd1, 2'd0, 52'hABCD_EFFF, 3'd4, 4'd7},  // R7
        '{64'h0000_8000_0000_0000, 52'h1000, 2'd1, 3'd0, 2'd0, 52'h0,         3'd0, 4'd2},  // R2
        '{64'hFFFF_7FFF_FFFF_FFFF, 52'h1000, 2'd1, 3'd0, 2'd0, 52'h0,         3'd0, 4'd2},  // R2
        '{64'h0000_7FFF_FFFF_FFFF, 52'h1000, 2'd2, 3'd4, 2'd0, 52'h0,         3'd1, 4'd10}, // R10
        '{64'hFFFF_8000_0000_0000, 52'h1000, 2'd0, 3'd1, 2'd0, 52'h1234_5000, 3'd4, 4'd10}, // R10
        '{64'h0000_0000_4000_0010, 52'h7ABC, 2'd0, 3'd3, 2'd2, 52'h4000_0010, 3'd2, 4'd3}   // R3
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_va = '0;
    logic [51:0] req_root = '0;
    logic        mem_req_valid;
    logic [51:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        res_valid;
    logic [1:0]  res_fault;
    logic [2:0]  res_level;
    logic [1:0]  res_size;
    logic [51:0] res_pa;

    int n_checks = 0;
    int n_fail   = 0;
    int rd_seen  = 0;
    logic [63:0] mem [512];

    always #2.5ns clk = ~clk;

    pgwalk_top u_pgwalk_top (.*);

    function automatic int hidx(logic [51:0] a);
        return int'({a[14:12], a[11], a[7:3]});
    endfunction

    task automatic put(logic [51:0] a, logic [63:0] v);
        mem[hidx(a)] = v;
    endtask

    task automatic check(logic ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // memory: answers a read pulse in the same cycle
    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mem_req_valid) begin
                rd_seen++;
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem[hidx(mem_req_addr)];
            end
        end
    end

    task automatic wait_result(output logic got);
        got = 1'b0;
        for (int c = 0; c < 40 && !got; c++) begin
            @(negedge clk);
            if (res_valid) got = 1'b1;
        end
    endtask

    task automatic judge(vec_t v, string tag);
        check(res_fault == v.kind, {tag, " fault"}, 64'(res_fault), 64'(v.kind));
        check(res_level == v.lvl,  {tag, " level"}, 64'(res_level), 64'(v.lvl));
        check(res_size == v.size,  {tag, " size"},  64'(res_size),  64'(v.size));
        check(res_pa == v.pa,      {tag, " pa"},    64'(res_pa),    64'(v.pa));
    endtask

    task automatic run_vec(vec_t v, string tag);
        logic got;
        @(negedge clk);
        rd_seen   = 0;
        req_valid = 1'b1; req_va = v.va; req_root = v.root;
        @(negedge clk);
        req_valid = 1'b0;
        wait_result(got);
        check(got, {tag, " result seen"}, 64'(got), 64'd1);
        judge(v, tag);
        check(rd_seen == int'(v.reads), {tag, " reads"}, 64'(rd_seen), 64'(v.reads));
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = '0;
        put(52'h1008, 64'h0000_0000_0000_2081);   // L4[1], large bit ignored (R7)
        put(52'h1800, 64'h0000_0000_0000_2001);   // L4[256]
        put(52'h2000, 64'h0000_0000_0000_3001);
        put(52'h2008, 64'h0000_0000_4123_4081);   // 1 GB, bits 29:12 stray
        put(52'h2018, 64'h0000_0000_0000_5001);
        put(52'h3000, 64'h0000_0000_0000_4001);
        put(52'h3008, 64'h0000_0000_00A0_5081);   // 2 MB, bits 20:12 stray
        put(52'h4000, 64'h8000_0000_1234_5001);   // 4 KB, bit 63 ignored
        put(52'h5000, 64'h0000_0000_0000_6001);
        put(52'h6028, 64'h0000_0000_ABCD_E081);   // L1 with bit 7 (R7)
        put(52'h7000, 64'h0000_0000_0000_2001);   // second root

        repeat (3) @(negedge clk);
        check(req_ready && !res_valid && !mem_req_valid, "R1 in reset",
              {61'd0, req_ready, res_valid, mem_req_valid}, 64'h4);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !res_valid && !mem_req_valid, "R1 after reset",
              {61'd0, req_ready, res_valid, mem_req_valid}, 64'h4);

        for (int i = 0; i < NV; i++)
            run_vec(VEC[i], $sformatf("R%0d vec%0d", VEC[i].tag, i));

        // R9: second request held through the first walk
        begin
            logic got;
            logic early;
            early = 1'b0;
            @(negedge clk);
            rd_seen   = 0;
            req_valid = 1'b1; req_va = VEC[0].va; req_root = VEC[0].root;
            @(negedge clk);
            req_va = VEC[2].va;
            got = 1'b0;
            for (int c = 0; c < 40 && !got; c++) begin
                if (req_ready) early = 1'b1;
                if (res_valid) got = 1'b1;
                else @(negedge clk);
            end
            check(got && !early, "R9 held request not taken early", 64'(early), 64'd0);
            check(!req_ready, "R9 not ready during result", 64'(req_ready), 64'd0);
            judge(VEC[0], "R9 first result");
            @(negedge clk);
            check(!res_valid && req_ready, "R9 pulse one cycle, ready after",
                  {62'd0, res_valid, req_ready}, 64'h1);
            @(negedge clk);
            req_valid = 1'b0;
            wait_result(got);
            check(got, "R9 second result seen", 64'(got), 64'd1);
            judge(VEC[2], "R9 second result");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule